// File: doc/BRIEF.md
# Spread-Pulse 8-Bit PWM Bank

This block is a bank of 8-bit pulse-width modulators. They spread each channel's high time over the whole period instead of producing one solid pulse. One period has 256 segments. A single segment counter, shared by every channel, steps one segment on each strobe of a segment-rate tick input. From the counter value the block decodes eight interleaved pulse trains, one for each data bit. The train for bit k is high in exactly 2^k segments of every period. Each channel outputs the OR of the trains whose bits are set in its data register. The total high time is therefore the data value in segments, with the ripple pushed to the highest possible frequency. That suits a simple RC filter that turns the output into a DC level.

Software-facing logic writes a channel's data register through a write port and reads it back through a read port. A new value drives the output from the next clock, wherever the counter is in the period. A stop input freezes the counter. A polarity input inverts every enabled channel. A per-channel enable holds an unused channel low.

Top module: `dpwm_bank`

## Requirements
- R1: While `cnt_stop_i` is 0, the shared segment counter advances by one on each clock where `seg_tick_i` is 1. It stays put when `seg_tick_i` is 0, and it wraps from 255 to 0, so one period is 256 ticks.
- R2: While `cnt_stop_i` is 1, the counter does not move, whatever `seg_tick_i` does, and every output holds its level.
- R3: For segment s not equal to 0, data bit k is active when the lowest set bit of s is at position 7−k. Bit 7 covers every odd segment, bit 6 covers segments where s mod 4 is 2, and bit 0 covers only segment 128. In segment 0 no bit is active.
- R4: With `invert_i` at 0, an enabled channel is high in exactly D segments of each 256-segment period, where D is its data value (0 to 255). It is never high in segment 0, so a fully high period cannot occur.
- R5: A write takes effect on the clock edge that captures it, so from the next cycle the output follows the new value, even in the middle of a period.
- R6: Reading channel n on `rd_data_o` returns exactly the last value written to it, and 0 after reset.
- R7: With `invert_i` at 1, every enabled channel outputs the complement of its non-inverted level, so it is high in 256−D segments per period.
- R8: A channel whose `ch_en_i` bit is 0 drives 0 on its output, whatever its data, the counter and `invert_i`.
- R9: All channels use the one shared counter, and each channel's output depends only on its own data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_tick_i | input | 1 | One-cycle strobe that advances the segment counter |
| cnt_stop_i | input | 1 | 1 freezes the segment counter |
| ch_en_i | input | NCH | Per-channel output enable |
| invert_i | input | 1 | Output polarity; 1 inverts enabled channels |
| wr_en_i | input | 1 | Data register write strobe |
| wr_sel_i | input | SELW | Channel addressed by a write |
| wr_data_i | input | 8 | Value to write |
| rd_sel_i | input | SELW | Channel addressed for readback |
| rd_data_o | output | 8 | Data register of the channel selected by `rd_sel_i` |
| pwm_o | output | NCH | PWM outputs, one bit per channel |

## Verification
Every cycle, the assertions check that the counter steps by one on a tick and freezes under stop or without a tick. They also check that a write lands in the addressed register on the next cycle, that disabled channels stay low, that segment 0 is low for every channel, and that odd segments are high for any channel with bit 7 set. Only the bench scenarios can show the per-period totals: that the high-segment count equals the data value for many patterns across all channels at once, that it becomes 256−D under inversion, that the period is exactly 256 ticks, and that a mid-period write changes the very next segment.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    localparam int DW   = 8;          // data width, also counter width
    localparam int NSEG = 1 << DW;    // segments per period

    typedef logic [DW-1:0] seg_t;
    typedef logic [DW-1:0] dat_t;

    // Bit k of the result is set when the lowest set bit of s sits at DW-1-k.
    function automatic dat_t train_mask(input seg_t s);
        dat_t m;
        logic found;
        m     = '0;
        found = 1'b0;
        for (int j = 0; j < DW; j++) begin
            if (s[j] && !found) begin
                m[DW-1-j] = 1'b1;
                found     = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/dpwm_seg_counter.sv
module dpwm_seg_counter
    import dpwm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic stop_i,
    output seg_t seg_o
);
    typedef struct packed {
        seg_t seg;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i && !stop_i) begin
            st_d.seg = st_q.seg + seg_t'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o = st_q.seg;
endmodule

// File: rtl/dpwm_regfile.sv
module dpwm_regfile
    import dpwm_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [SELW-1:0]     wr_sel_i,
    input  dat_t                wr_data_i,
    input  logic [SELW-1:0]     rd_sel_i,
    output dat_t                rd_data_o,
    output logic [NCH-1:0][DW-1:0] data_o
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NCH; n++) begin
            if (wr_en_i && (int'(wr_sel_i) == n)) begin
                st_d.data[n] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int n = 0; n < NCH; n++) begin
            if (int'(rd_sel_i) == n) begin
                rd_data_o = st_q.data[n];
            end
        end
    end

    assign data_o = st_q.data;
endmodule

// File: rtl/dpwm_out_stage.sv
module dpwm_out_stage
    import dpwm_pkg::*;
#(
    parameter int NCH = 8
) (
    input  seg_t                   seg_i,
    input  logic [NCH-1:0][DW-1:0] data_i,
    input  logic [NCH-1:0]         en_i,
    input  logic                   inv_i,
    output logic [NCH-1:0]         pwm_o
);
    dat_t active_trains;

    assign active_trains = train_mask(seg_i);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic raw;
        assign raw      = |(data_i[n] & active_trains);
        assign pwm_o[n] = en_i[n] & (raw ^ inv_i);
    end
endmodule

// File: rtl/dpwm_bank.sv
module dpwm_bank
    import dpwm_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            seg_tick_i,
    input  logic            cnt_stop_i,
    input  logic [NCH-1:0]  ch_en_i,
    input  logic            invert_i,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  logic [7:0]      wr_data_i,
    input  logic [SELW-1:0] rd_sel_i,
    output logic [7:0]      rd_data_o,
    output logic [NCH-1:0]  pwm_o
);
    seg_t                   seg_cnt;
    logic [NCH-1:0][DW-1:0] ch_data;

    dpwm_seg_counter u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (seg_tick_i),
        .stop_i (cnt_stop_i),
        .seg_o  (seg_cnt)
    );

    dpwm_regfile #(.NCH(NCH)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .data_o    (ch_data)
    );

    dpwm_out_stage #(.NCH(NCH)) u_out (
        .seg_i  (seg_cnt),
        .data_i (ch_data),
        .en_i   (ch_en_i),
        .inv_i  (invert_i),
        .pwm_o  (pwm_o)
    );
endmodule

// File: rtl/dpwm_bank_chk.sv
module dpwm_bank_chk
    import dpwm_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   seg_tick_i,
    input logic                   cnt_stop_i,
    input logic [NCH-1:0]         ch_en_i,
    input logic                   invert_i,
    input logic                   wr_en_i,
    input logic [SELW-1:0]        wr_sel_i,
    input logic [7:0]             wr_data_i,
    input logic [NCH-1:0]         pwm_o,
    input seg_t                   seg_cnt,
    input logic [NCH-1:0][DW-1:0] ch_data
);
    a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_tick_i && !cnt_stop_i) |=> seg_cnt == $past(seg_cnt) + seg_t'(1));

    a_r1_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seg_tick_i |=> $stable(seg_cnt));

    a_r2_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_stop_i |=> $stable(seg_cnt));

    a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> ch_data[$past(wr_sel_i)] == $past(wr_data_i));

    a_r4_seg0_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_cnt == '0) |-> pwm_o == (ch_en_i & {NCH{invert_i}}));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        a_r8_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ch_en_i[n] |-> !pwm_o[n]);

        a_r3_odd_seg_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (seg_cnt[0] && ch_en_i[n] && ch_data[n][DW-1]) |-> pwm_o[n] == !invert_i);
    end
endmodule

bind dpwm_bank dpwm_bank_chk #(.NCH(NCH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seg_tick_i (seg_tick_i),
    .cnt_stop_i (cnt_stop_i),
    .ch_en_i    (ch_en_i),
    .invert_i   (invert_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .pwm_o      (pwm_o),
    .seg_cnt    (seg_cnt),
    .ch_data    (ch_data)
);

// File: tb/dpwm_bank_tb.sv
module dpwm_bank_tb;
    localparam int NCH  = 8;
    localparam int SELW = 3;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            seg_tick_i = 1'b0;
    logic            cnt_stop_i = 1'b0;
    logic [NCH-1:0]  ch_en_i = '1;
    logic            invert_i = 1'b0;
    logic            wr_en_i = 1'b0;
    logic [SELW-1:0] wr_sel_i = '0;
    logic [7:0]      wr_data_i = '0;
    logic [SELW-1:0] rd_sel_i = '0;
    logic [7:0]      rd_data_o;
    logic [NCH-1:0]  pwm_o;

    dpwm_bank #(.NCH(NCH)) u_dut (.*);

    always #5 clk_i = ~clk_i;

    int n_checks = 0;
    int n_fail   = 0;
    int hi_cnt [NCH];
    bit finished = 1'b0;

    // Data patterns; per period the high-segment count must equal the value.
    localparam logic [7:0] VALS [8] = '{8'h00, 8'h01, 8'h80, 8'hFF,
                                        8'hAA, 8'h55, 8'h03, 8'h7E};

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [7:0] v);
        wr_en_i   = 1'b1;
        wr_sel_i  = SELW'(ch);
        wr_data_i = v;
        @(posedge clk_i);
        #1 wr_en_i = 1'b0;
    endtask

    task automatic run_period();
        for (int n = 0; n < NCH; n++) hi_cnt[n] = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk_i);
            for (int n = 0; n < NCH; n++) hi_cnt[n] += int'(pwm_o[n]);
        end
    endtask

    initial begin
        #1_800_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // Reset state: R6 readback zero, outputs low
        for (int n = 0; n < NCH; n++) begin
            rd_sel_i = SELW'(n);
            #1 check("R6 reset readback", int'(rd_data_o), 0);
        end
        check("R4 reset output", int'(pwm_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        seg_tick_i = 1'b1;

        // Vector table walk: R4, R9 (distinct values on all channels), R6
        for (int r = 0; r < 4; r++) begin
            @(negedge clk_i);
            for (int n = 0; n < NCH; n++) wr(n, VALS[(r + n) % 8]);
            @(negedge clk_i);
            for (int n = 0; n < NCH; n++) begin
                rd_sel_i = SELW'(n);
                #1 check("R6 readback", int'(rd_data_o), int'(VALS[(r + n) % 8]));
            end
            run_period();
            for (int n = 0; n < NCH; n++)
                check("R4/R9 high count", hi_cnt[n], int'(VALS[(r + n) % 8]));
        end

        // R3: bit 7 alone toggles every segment; bit 6 alone every other
        @(negedge clk_i);
        wr(0, 8'h80);
        wr(1, 8'h40);
        @(negedge clk_i);
        begin
            logic p0;
            int toggles;
            toggles = 0;
            p0 = pwm_o[0];
            for (int i = 0; i < 16; i++) begin
                @(negedge clk_i);
                if (pwm_o[0] != p0) toggles++;
                p0 = pwm_o[0];
            end
            check("R3 bit7 odd segments toggle", toggles, 16);
        end
        run_period();
        check("R3 bit6 alone count", hi_cnt[1], 64);
        check("R3 bit7 alone count", hi_cnt[0], 128);

        // R1: bit 0 alone is high once; distance between highs is 256 ticks
        @(negedge clk_i);
        wr(2, 8'h01);
        begin
            int gap;
            int guard;
            guard = 0;
            @(negedge clk_i);
            while (!pwm_o[2] && guard < 300) begin
                @(negedge clk_i);
                guard++;
            end
            gap = 0;
            @(negedge clk_i);
            gap = 1;
            while (!pwm_o[2] && gap < 300) begin
                @(negedge clk_i);
                gap++;
            end
            check("R1 period length", gap, 256);
            // now at segment 128: R5 mid-period write of bit 7 shows at 129
            wr(2, 8'h80);
            @(negedge clk_i);
            check("R5 write effective next segment", int'(pwm_o[2]), 1);
        end

        // R1: without tick the output of a bit-7 channel holds
        seg_tick_i = 1'b0;
        begin
            int changes;
            logic p;
            changes = 0;
            p = pwm_o[0];
            for (int i = 0; i < 20; i++) begin
                @(negedge clk_i);
                if (pwm_o[0] != p) changes++;
            end
            check("R1 no tick holds", changes, 0);
        end

        // R2: stop freezes even with tick high
        seg_tick_i = 1'b1;
        cnt_stop_i = 1'b1;
        begin
            int changes;
            logic p;
            changes = 0;
            @(negedge clk_i);
            p = pwm_o[0];
            for (int i = 0; i < 20; i++) begin
                @(negedge clk_i);
                if (pwm_o[0] != p) changes++;
            end
            check("R2 stop holds", changes, 0);
        end
        cnt_stop_i = 1'b0;

        // R7: inversion gives 256-D high segments
        @(negedge clk_i);
        wr(3, 8'h40);
        wr(4, 8'h00);
        invert_i = 1'b1;
        run_period();
        check("R7 inverted count 0x40", hi_cnt[3], 192);
        check("R7 inverted count 0x00", hi_cnt[4], 256);

        // R8: disabled channels stay low even inverted with data set
        ch_en_i = 8'b1110_0111;
        run_period();
        check("R8 disabled ch3 low", hi_cnt[3], 0);
        check("R8 disabled ch4 low", hi_cnt[4], 0);
        check("R9 enabled ch0 unaffected", hi_cnt[0], 128);
        invert_i = 1'b0;
        ch_en_i = '1;

        // R4: maximum value never fully high
        @(negedge clk_i);
        wr(5, 8'hFF);
        run_period();
        check("R4 max value 255 of 256", hi_cnt[5], 255);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule